// File: doc/BRIEF.md
# Function-Unit to Register Dependency Matrix

This block is the register side of a scoreboard. It keeps one row for each function-unit slot and tracks the registers each issued operation depends on. For every row it holds a busy flag, a need-read flag for each of two source operands and a need-write flag for one destination register. Rows are grouped into consecutive sets that share one ALU. Each row keeps its own latched copy of its source operand values, so several operations can wait on the same ALU in the way reservation stations do.

At issue, the issue stage names a row and gives two optional source register indices with their register-file values, plus an optional destination index. A source whose register has no pending write is captured from the supplied value at once. A source whose register has a pending write is marked need-read and waits. When the producing row writes back, its result is broadcast, and every row waiting on that register captures the value.

The block reports the pending-write state of each register, which rows have all their operands, which ALUs have a ready row, and whether an issue attempt would create a write-after-write conflict.

Top module: `fum_matrix`

## Requirements
- R1: After reset, every row is free, no register has a pending write, and `rd_ready` and `alu_ready` are all zero.
- R2: An issue is accepted (`issue_ok` high in the same cycle) only when `issue_valid` is high, row `issue_row` is free, and there is no WAW conflict. In the cycle after an accepted issue, that row is busy, and if `issue_dst_v` was set, bit `issue_dst` of `pend_wr` is set.
- R3: A valid source whose register has no pending write is captured from `issue_src1_val`/`issue_src2_val` at issue. A source whose valid bit is clear needs nothing. If neither source is waiting, the row's `rd_ready` bit is high in the next cycle, and its operands appear on `row_opa`/`row_opb`, with row i at bits [i*DW +: DW].
- R4: A valid source whose register has a pending write keeps the row's `rd_ready` low. In the cycle after the writing row's accepted write-back, the waiting row holds `wb_data` as that operand and, if no other source is waiting, raises `rd_ready`.
- R5: If an issue reads a register whose writer is accepted for write-back in the same cycle, the source is captured directly from `wb_data`, and the row is ready in the next cycle.
- R6: If `issue_valid` and `issue_dst_v` are high and bit `issue_dst` of `pend_wr` is set, `waw_conflict` is high in that cycle and the issue is ignored.
- R7: An issue naming a busy row is ignored: `issue_ok` is low, and the row's state and the pending writes are unchanged.
- R8: A write-back to row `wb_row` is accepted only if that row is busy and read-complete. In the next cycle the row is free and its pending write is cleared. A write-back to a row that is still waiting for an operand is ignored.
- R9: A kill frees row `kill_row` and clears its pending write in the next cycle. It broadcasts no value, and it takes priority over a write-back to the same row.
- R10: `alu_ready[a]` is the OR of `rd_ready` over rows a*ROWS_PER_ALU to a*ROWS_PER_ALU+ROWS_PER_ALU-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Issue attempt this cycle |
| issue_row | input | $clog2(NROWS) | Target row |
| issue_src1_v | input | 1 | Source 1 present |
| issue_src1_idx | input | $clog2(NREGS) | Source 1 register |
| issue_src1_val | input | DW | Source 1 register-file value |
| issue_src2_v | input | 1 | Source 2 present |
| issue_src2_idx | input | $clog2(NREGS) | Source 2 register |
| issue_src2_val | input | DW | Source 2 register-file value |
| issue_dst_v | input | 1 | Destination present |
| issue_dst | input | $clog2(NREGS) | Destination register |
| issue_ok | output | 1 | Issue accepted this cycle |
| waw_conflict | output | 1 | Destination already has a pending write |
| wb_valid | input | 1 | Write-back strobe |
| wb_row | input | $clog2(NROWS) | Row writing back |
| wb_data | input | DW | Result being written back |
| kill_valid | input | 1 | Kill strobe |
| kill_row | input | $clog2(NROWS) | Row to kill |
| pend_wr | output | NREGS | Per-register pending write |
| row_busy | output | NROWS | Row occupied |
| rd_ready | output | NROWS | Row busy with all operands captured |
| alu_ready | output | NROWS/ROWS_PER_ALU | Some row of the ALU group is ready |
| row_opa | output | NROWS*DW | Captured source 1 values, by row |
| row_opb | output | NROWS*DW | Captured source 2 values, by row |

## Verification
`issue_ok` and `waw_conflict` are combinational, so they are due in the same cycle as the issue attempt. The bench samples them after driving the inputs and before the clock edge. Every other result comes from row registers and is due one edge after the strobe that caused it: issue, write-back or kill. The bench samples those one time step after that edge, once the strobes have been withdrawn. Each dependent scenario also samples once while the operation is still waiting, before the producing write-back, so a row that wakes up early is caught.

// File: rtl/fum_pkg.sv
package fum_pkg;
    typedef struct packed {
        logic busy;
        logic nr1;
        logic nr2;
        logic nw;
    } row_flags_t;
endpackage

// File: rtl/fum_row.sv
module fum_row #(
    parameter int DW  = 16,
    parameter int RIW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ld,
    input  logic           ld_nr1,
    input  logic           ld_nr2,
    input  logic           ld_nw,
    input  logic [RIW-1:0] ld_s1,
    input  logic [RIW-1:0] ld_s2,
    input  logic [RIW-1:0] ld_dst,
    input  logic [DW-1:0]  ld_opa,
    input  logic [DW-1:0]  ld_opb,
    input  logic           retire,
    input  logic           kill,
    input  logic           bc_fire,
    input  logic [RIW-1:0] bc_reg,
    input  logic [DW-1:0]  bc_data,
    output logic           busy,
    output logic           rd_done,
    output logic           nw,
    output logic [RIW-1:0] dst,
    output logic [DW-1:0]  opa,
    output logic [DW-1:0]  opb
);
    typedef struct packed {
        fum_pkg::row_flags_t f;
        logic [RIW-1:0]      s1;
        logic [RIW-1:0]      s2;
        logic [RIW-1:0]      dst;
        logic [DW-1:0]       opa;
        logic [DW-1:0]       opb;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (kill || retire) begin
            st_d.f = '0;
        end else if (ld) begin
            st_d.f.busy = 1'b1;
            st_d.f.nr1  = ld_nr1;
            st_d.f.nr2  = ld_nr2;
            st_d.f.nw   = ld_nw;
            st_d.s1     = ld_s1;
            st_d.s2     = ld_s2;
            st_d.dst    = ld_dst;
            st_d.opa    = ld_opa;
            st_d.opb    = ld_opb;
        end else if (st_q.f.busy && bc_fire) begin
            if (st_q.f.nr1 && st_q.s1 == bc_reg) begin
                st_d.f.nr1 = 1'b0;
                st_d.opa   = bc_data;
            end
            if (st_q.f.nr2 && st_q.s2 == bc_reg) begin
                st_d.f.nr2 = 1'b0;
                st_d.opb   = bc_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.f.busy;
    assign rd_done = st_q.f.busy && !st_q.f.nr1 && !st_q.f.nr2;
    assign nw      = st_q.f.nw;
    assign dst     = st_q.dst;
    assign opa     = st_q.opa;
    assign opb     = st_q.opb;
endmodule

// File: rtl/fum_pend_or.sv
module fum_pend_or #(
    parameter int NROWS = 4,
    parameter int NREGS = 8,
    localparam int RIW  = $clog2(NREGS)
) (
    input  logic [NROWS-1:0]     nw,
    input  logic [NROWS*RIW-1:0] dst_flat,
    output logic [NREGS-1:0]     pend
);
    always_comb begin
        pend = '0;
        for (int r = 0; r < NREGS; r++) begin
            for (int i = 0; i < NROWS; i++) begin
                if (nw[i] && dst_flat[i*RIW +: RIW] == RIW'(r)) pend[r] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fum_alu_group.sv
module fum_alu_group #(
    parameter int NROWS        = 4,
    parameter int ROWS_PER_ALU = 2,
    localparam int NALU        = NROWS / ROWS_PER_ALU
) (
    input  logic [NROWS-1:0] rd_ready,
    output logic [NALU-1:0]  alu_ready
);
    for (genvar a = 0; a < NALU; a++) begin : g_alu
        assign alu_ready[a] = |rd_ready[a*ROWS_PER_ALU +: ROWS_PER_ALU];
    end
endmodule

// File: rtl/fum_matrix.sv
module fum_matrix #(
    parameter int NROWS        = 4,
    parameter int NREGS        = 8,
    parameter int DW           = 16,
    parameter int ROWS_PER_ALU = 2,
    localparam int RIW         = $clog2(NREGS),
    localparam int ROWW        = $clog2(NROWS),
    localparam int NALU        = NROWS / ROWS_PER_ALU
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  issue_valid,
    input  logic [ROWW-1:0]       issue_row,
    input  logic                  issue_src1_v,
    input  logic [RIW-1:0]        issue_src1_idx,
    input  logic [DW-1:0]         issue_src1_val,
    input  logic                  issue_src2_v,
    input  logic [RIW-1:0]        issue_src2_idx,
    input  logic [DW-1:0]         issue_src2_val,
    input  logic                  issue_dst_v,
    input  logic [RIW-1:0]        issue_dst,
    output logic                  issue_ok,
    output logic                  waw_conflict,
    input  logic                  wb_valid,
    input  logic [ROWW-1:0]       wb_row,
    input  logic [DW-1:0]         wb_data,
    input  logic                  kill_valid,
    input  logic [ROWW-1:0]       kill_row,
    output logic [NREGS-1:0]      pend_wr,
    output logic [NROWS-1:0]      row_busy,
    output logic [NROWS-1:0]      rd_ready,
    output logic [NALU-1:0]       alu_ready,
    output logic [NROWS*DW-1:0]   row_opa,
    output logic [NROWS*DW-1:0]   row_opb
);
    logic [NROWS-1:0]     nw_v;
    logic [NROWS*RIW-1:0] dst_flat;
    logic                 wb_fire, bc_fire;
    logic [RIW-1:0]       bc_reg;
    logic                 nr1_d, nr2_d;
    logic [DW-1:0]        opa_d, opb_d;

    fum_pend_or #(.NROWS(NROWS), .NREGS(NREGS)) pend_i (
        .nw(nw_v), .dst_flat(dst_flat), .pend(pend_wr)
    );

    fum_alu_group #(.NROWS(NROWS), .ROWS_PER_ALU(ROWS_PER_ALU)) grp_i (
        .rd_ready(rd_ready), .alu_ready(alu_ready)
    );

    always_comb begin
        waw_conflict = issue_valid && issue_dst_v && pend_wr[issue_dst];
        issue_ok     = issue_valid && !row_busy[issue_row] && !waw_conflict;
        wb_fire      = wb_valid && rd_ready[wb_row] &&
                       !(kill_valid && kill_row == wb_row);
        bc_fire      = wb_fire && nw_v[wb_row];
        bc_reg       = dst_flat[wb_row*RIW +: RIW];

        nr1_d = 1'b0;
        opa_d = issue_src1_val;
        if (issue_src1_v && pend_wr[issue_src1_idx]) begin
            if (bc_fire && bc_reg == issue_src1_idx) opa_d = wb_data;
            else                                     nr1_d = 1'b1;
        end
        nr2_d = 1'b0;
        opb_d = issue_src2_val;
        if (issue_src2_v && pend_wr[issue_src2_idx]) begin
            if (bc_fire && bc_reg == issue_src2_idx) opb_d = wb_data;
            else                                     nr2_d = 1'b1;
        end
    end

    for (genvar i = 0; i < NROWS; i++) begin : g_row
        fum_row #(.DW(DW), .RIW(RIW)) row_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .ld      (issue_ok && issue_row == ROWW'(i)),
            .ld_nr1  (nr1_d),
            .ld_nr2  (nr2_d),
            .ld_nw   (issue_dst_v),
            .ld_s1   (issue_src1_idx),
            .ld_s2   (issue_src2_idx),
            .ld_dst  (issue_dst),
            .ld_opa  (opa_d),
            .ld_opb  (opb_d),
            .retire  (wb_fire && wb_row == ROWW'(i)),
            .kill    (kill_valid && kill_row == ROWW'(i)),
            .bc_fire (bc_fire),
            .bc_reg  (bc_reg),
            .bc_data (wb_data),
            .busy    (row_busy[i]),
            .rd_done (rd_ready[i]),
            .nw      (nw_v[i]),
            .dst     (dst_flat[i*RIW +: RIW]),
            .opa     (row_opa[i*DW +: DW]),
            .opb     (row_opb[i*DW +: DW])
        );
    end
endmodule

// File: rtl/fum_matrix_chk.sv
module fum_matrix_chk #(
    parameter int NROWS = 4,
    parameter int NREGS = 8,
    localparam int RIW  = $clog2(NREGS),
    localparam int ROWW = $clog2(NROWS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             issue_valid,
    input logic [ROWW-1:0]  issue_row,
    input logic             issue_dst_v,
    input logic [RIW-1:0]   issue_dst,
    input logic             issue_ok,
    input logic             waw_conflict,
    input logic             kill_valid,
    input logic [ROWW-1:0]  kill_row,
    input logic [NREGS-1:0] pend_wr,
    input logic [NROWS-1:0] row_busy,
    input logic [NROWS-1:0] rd_ready
);
    // R7
    busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid && row_busy[issue_row] |-> !issue_ok);
    // R6
    waw_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        waw_conflict |-> !issue_ok);
    // R2
    issue_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_ok && issue_dst_v |=> pend_wr[$past(issue_dst)] && row_busy[$past(issue_row)]);
    // R9
    kill_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill_valid |=> !row_busy[$past(kill_row)]);
    // R3
    ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ready & ~row_busy) == '0);
    // R8
    pend_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pend_wr) <= $countones(row_busy));
endmodule

bind fum_matrix fum_matrix_chk #(.NROWS(NROWS), .NREGS(NREGS)) chk_i (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_row(issue_row),
    .issue_dst_v(issue_dst_v), .issue_dst(issue_dst), .issue_ok(issue_ok),
    .waw_conflict(waw_conflict), .kill_valid(kill_valid), .kill_row(kill_row),
    .pend_wr(pend_wr), .row_busy(row_busy), .rd_ready(rd_ready)
);

// File: tb/fum_matrix_tb.sv
module fum_matrix_tb_top;
    localparam int NROWS = 4, NREGS = 8, DW = 16, RPA = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic issue_valid = 0, s1v = 0, s2v = 0, dv = 0;
    logic [1:0] issue_row = 0;
    logic [2:0] s1i = 0, s2i = 0, di = 0;
    logic [15:0] s1val = 0, s2val = 0;
    logic issue_ok, waw_conflict;
    logic wb_valid = 0, kill_valid = 0;
    logic [1:0] wb_row = 0, kill_row = 0;
    logic [15:0] wb_data = 0;
    logic [7:0] pend_wr;
    logic [3:0] row_busy, rd_ready;
    logic [1:0] alu_ready;
    logic [63:0] row_opa, row_opb;

    int total = 0, bad = 0;

    fum_matrix #(.NROWS(NROWS), .NREGS(NREGS), .DW(DW), .ROWS_PER_ALU(RPA)) dut_i (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_row(issue_row),
        .issue_src1_v(s1v), .issue_src1_idx(s1i), .issue_src1_val(s1val),
        .issue_src2_v(s2v), .issue_src2_idx(s2i), .issue_src2_val(s2val),
        .issue_dst_v(dv), .issue_dst(di), .issue_ok(issue_ok),
        .waw_conflict(waw_conflict), .wb_valid(wb_valid), .wb_row(wb_row),
        .wb_data(wb_data), .kill_valid(kill_valid), .kill_row(kill_row),
        .pend_wr(pend_wr), .row_busy(row_busy), .rd_ready(rd_ready),
        .alu_ready(alu_ready), .row_opa(row_opa), .row_opb(row_opb)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Drive an issue; inputs are stable one step after an edge.
    task automatic set_issue(input logic [1:0] row, input logic a_v, input logic [2:0] a_i,
                             input logic [15:0] a_val, input logic b_v, input logic [2:0] b_i,
                             input logic [15:0] b_val, input logic d_v, input logic [2:0] d_i);
        issue_valid = 1; issue_row = row;
        s1v = a_v; s1i = a_i; s1val = a_val;
        s2v = b_v; s2i = b_i; s2val = b_val;
        dv = d_v; di = d_i;
    endtask

    task automatic step();
        @(posedge clk); #1;
        issue_valid = 0; wb_valid = 0; kill_valid = 0;
    endtask

    task automatic wb(input logic [1:0] row, input logic [15:0] data);
        wb_valid = 1; wb_row = row; wb_data = data;
    endtask

    function automatic logic [15:0] opa(input int r); return row_opa[r*DW +: DW]; endfunction
    function automatic logic [15:0] opb(input int r); return row_opb[r*DW +: DW]; endfunction

    task automatic t_reset();
        chk("R1 busy", row_busy, 0);
        chk("R1 pend", pend_wr, 0);
        chk("R1 ready", rd_ready, 0);
        chk("R1 alu", alu_ready, 0);
    endtask

    task automatic t_indep();
        set_issue(0, 1, 1, 16'h11, 1, 2, 16'h22, 1, 5);
        #1 chk("R2 ok", issue_ok, 1);
        step();
        chk("R2 busy", row_busy, 4'b0001);
        chk("R2 pend", pend_wr, 8'h20);
        chk("R3 ready", rd_ready, 4'b0001);
        chk("R3 opa", opa(0), 16'h11);
        chk("R3 opb", opb(0), 16'h22);
        chk("R10 alu", alu_ready, 2'b01);
        wb(0, 16'h55);
        step();
        chk("R8 free", row_busy, 0);
        chk("R8 pend", pend_wr, 0);
    endtask

    task automatic t_dep();
        set_issue(0, 1, 1, 16'h1, 1, 2, 16'h2, 1, 3);
        step();
        set_issue(2, 1, 3, 16'hdead, 1, 4, 16'h44, 1, 6);
        step();
        chk("R4 wait", rd_ready, 4'b0001);
        chk("R4 pend", pend_wr, 8'h48);
        chk("R10 alu grp", alu_ready, 2'b01);
        wb(2, 16'h9999);
        step();
        chk("R8 ignored busy", row_busy, 4'b0101);
        chk("R8 ignored pend", pend_wr, 8'h48);
        wb(0, 16'h1234);
        step();
        chk("R4 ready", rd_ready, 4'b0100);
        chk("R4 opa", opa(2), 16'h1234);
        chk("R4 opb", opb(2), 16'h44);
        chk("R4 pend", pend_wr, 8'h40);
        chk("R10 alu hi", alu_ready, 2'b10);
        wb(2, 16'h0);
        step();
        chk("R8 retire", row_busy, 0);
    endtask

    task automatic t_waw_busy();
        set_issue(1, 0, 0, 0, 0, 0, 0, 1, 7);
        step();
        set_issue(3, 0, 0, 0, 0, 0, 0, 1, 7);
        #1 chk("R6 waw", waw_conflict, 1);
        chk("R6 ok", issue_ok, 0);
        step();
        chk("R6 ignored", row_busy, 4'b0010);
        set_issue(1, 1, 2, 16'h77, 0, 0, 0, 1, 0);
        #1 chk("R7 ok", issue_ok, 0);
        step();
        chk("R7 pend", pend_wr, 8'h80);
        chk("R7 busy", row_busy, 4'b0010);
    endtask

    task automatic t_kill();
        set_issue(3, 1, 7, 16'haaaa, 0, 0, 0, 0, 0);
        step();
        chk("R4 wait kill", rd_ready, 4'b0010);
        kill_valid = 1; kill_row = 1;
        wb(1, 16'hbbbb);
        step();
        chk("R9 busy", row_busy, 4'b1000);
        chk("R9 pend", pend_wr, 0);
        chk("R9 no bcast", rd_ready, 0);
        kill_valid = 1; kill_row = 3;
        step();
        chk("R9 clean", row_busy, 0);
    endtask

    task automatic t_bypass();
        set_issue(0, 0, 0, 0, 0, 0, 0, 1, 2);
        step();
        wb(0, 16'hbeef);
        set_issue(1, 1, 2, 16'h0bad, 0, 0, 0, 1, 4);
        step();
        chk("R5 ready", rd_ready, 4'b0010);
        chk("R5 opa", opa(1), 16'hbeef);
        chk("R5 pend", pend_wr, 8'h10);
        wb(1, 16'h1);
        step();
        chk("R8 bypass retire", row_busy, 0);
    endtask

    task automatic t_nosrc();
        set_issue(2, 0, 0, 0, 0, 0, 0, 0, 0);
        step();
        chk("R3 nosrc ready", rd_ready, 4'b0100);
        chk("R3 nosrc pend", pend_wr, 0);
        wb(2, 16'h0);
        step();
        chk("R8 nosrc retire", row_busy, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_indep();
        t_dep();
        t_waw_busy();
        t_kill();
        t_bypass();
        t_nosrc();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule